// File: doc/BRIEF.md
# DMA Channel Control Registers

This block is the register and control front end of a single DMA channel. Software reaches it through a 32-bit memory-mapped register port. Through that port it programs a byte count, the address of the first descriptor and the transfer direction, and then launches the transfer through a command/status word. A small sequencer turns an accepted launch into a one-cycle `go_o` pulse for an external data mover. It keeps the channel marked active until the mover reports completion on `done_i`. At completion it raises an interrupt flag, which software clears by writing a one to the clear bit.

The register map uses byte offsets on 32-bit words. Offset 0x0 is the transfer count, offset 0x4 is the descriptor pointer and offset 0x8 is command/status. Any other offset is unmapped, and so is any access whose address has non-zero bits [1:0]. Reads are combinational from `addr_i`. A write takes effect at the rising clock edge where `wr_en_i` is high.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, the count register reads 0, the pointer reads 0x00000001, command/status reads 0x00000010, and `go_o` and `irq_o` are low.
- R2: The count register (offset 0x0) stores the low CNT_W bits of a write. Bits 31:CNT_W always read zero. `xfer_bytes_o` presents the stored count.
- R3: In the pointer register (offset 0x4), bit 0 always reads one and bits 2:1 always read zero. Bits 31:4 hold the descriptor address. `desc_addr_o` is that address with its low four bits forced to zero.
- R4: Pointer bit 3 is the direction flag (1 = local memory to host, 0 = host to local memory). It reads back and drives `dir_o`.
- R5: Command/status bit 0 is enable. A write with bit 1 and bit 0 both set, made while the channel is inactive, makes `go_o` high for exactly the one cycle after the write edge. It also makes status bit 4 (inactive) read zero.
- R6: A write with bit 1 set and bit 0 clear launches nothing. `go_o` stays low and bit 4 stays one.
- R7: A launch write made while a transfer is active is ignored. No `go_o` pulse follows.
- R8: `done_i` while active sets bit 4 back to one and sets the interrupt flag. `done_i` while inactive has no effect. `irq_o` equals the flag ANDed with the enable bit.
- R9: Writing command/status with bit 3 set clears the interrupt flag. Writing it with bit 3 clear leaves the flag unchanged.
- R10: When completion and a clear write fall in the same cycle, the flag ends up set.
- R11: Offset 0xC and misaligned addresses read zero, and writes to them change nothing.
- R12: Command/status bits 1–3 and 5–31 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| done_i | input | 1 | Completion from the data mover |
| go_o | output | 1 | One-cycle launch pulse to the data mover |
| xfer_bytes_o | output | CNT_W | Programmed byte count |
| desc_addr_o | output | 32 | First descriptor address, 16-byte aligned |
| dir_o | output | 1 | Transfer direction |
| irq_o | output | 1 | Channel interrupt |

## Verification
The bench builds the block with CNT_W = 8 and ADDR_W = 4. The narrow count lets it sweep every count value, each written with set upper bits, so the masking boundary is covered exhaustively. The four-word window lets it probe the single unmapped slot and the misaligned addresses directly. Pointer patterns are generated arithmetically to reach every address bit and both directions. Walks through the control sequence cover launch, launch refusal, completion, masking and clearing of the interrupt, and the clash between a completion and a clear in the same cycle.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int DW       = 32;
  // word indices within the register window
  localparam int IDX_CNT  = 0;
  localparam int IDX_PTR  = 1;
  localparam int IDX_CTRL = 2;
  // command/status bits
  localparam int CB_EN    = 0;
  localparam int CB_GO    = 1;
  localparam int CB_CLR   = 3;
  localparam int CB_IDLE  = 4;
  // pointer bits
  localparam int PB_SPACE = 0;
  localparam int PB_DIR   = 3;
  localparam int PB_ADDR  = 4;
endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs #(
  parameter int CNT_W = 23
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   cnt_we_i,
  input  logic                                   ptr_we_i,
  input  logic [CNT_W-1:0]                       cnt_wdata_i,
  input  logic [dma_chan_pkg::DW-1:dma_chan_pkg::PB_DIR] ptr_wdata_i,
  output logic [CNT_W-1:0]                       cnt_o,
  output logic [dma_chan_pkg::DW-1:dma_chan_pkg::PB_ADDR] base_o,
  output logic                                   dir_o
);
  import dma_chan_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= '0;
      base_o <= '0;
      dir_o  <= 1'b0;
    end else begin
      if (cnt_we_i) cnt_o <= cnt_wdata_i;
      if (ptr_we_i) begin
        base_o <= ptr_wdata_i[DW-1:PB_ADDR];
        dir_o  <= ptr_wdata_i[PB_DIR];
      end
    end
  end
endmodule

// File: rtl/dma_seq.sv
module dma_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_we_i,
  input  logic en_wr_i,
  input  logic go_wr_i,
  input  logic clr_wr_i,
  input  logic done_i,
  output logic en_o,
  output logic idle_o,
  output logic flag_o,
  output logic go_o,
  output logic irq_o
);
  logic accept, finish;

  // launch uses the enable value carried by the same write
  assign accept = ctrl_we_i & go_wr_i & en_wr_i & idle_o;
  assign finish = done_i & ~idle_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      idle_o <= 1'b1;
      flag_o <= 1'b0;
      go_o   <= 1'b0;
    end else begin
      go_o <= accept;
      if (ctrl_we_i) en_o <= en_wr_i;
      if (finish)      idle_o <= 1'b1;
      else if (accept) idle_o <= 1'b0;
      // completion beats a same-cycle clear
      if (finish)                     flag_o <= 1'b1;
      else if (ctrl_we_i && clr_wr_i) flag_o <= 1'b0;
    end
  end

  assign irq_o = flag_o & en_o;
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int CNT_W  = 23,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              done_i,
  output logic              go_o,
  output logic [CNT_W-1:0]  xfer_bytes_o,
  output logic [31:0]       desc_addr_o,
  output logic              dir_o,
  output logic              irq_o
);
  import dma_chan_pkg::*;

  localparam int WI_W = ADDR_W - 2;
  localparam logic [WI_W-1:0] W_CNT  = WI_W'(IDX_CNT);
  localparam logic [WI_W-1:0] W_PTR  = WI_W'(IDX_PTR);
  localparam logic [WI_W-1:0] W_CTRL = WI_W'(IDX_CTRL);

  logic [WI_W-1:0] widx;
  logic            aligned, sel_cnt, sel_ptr, sel_ctrl;
  logic [DW-1:PB_ADDR] base;
  logic en, idle, irq_flag;

  assign widx     = addr_i[ADDR_W-1:2];
  assign aligned  = (addr_i[1:0] == 2'b00);
  assign sel_cnt  = aligned && (widx == W_CNT);
  assign sel_ptr  = aligned && (widx == W_PTR);
  assign sel_ctrl = aligned && (widx == W_CTRL);

  dma_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cnt_we_i    (wr_en_i & sel_cnt),
    .ptr_we_i    (wr_en_i & sel_ptr),
    .cnt_wdata_i (wdata_i[CNT_W-1:0]),
    .ptr_wdata_i (wdata_i[DW-1:PB_DIR]),
    .cnt_o       (xfer_bytes_o),
    .base_o      (base),
    .dir_o       (dir_o)
  );

  dma_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_we_i (wr_en_i & sel_ctrl),
    .en_wr_i   (wdata_i[CB_EN]),
    .go_wr_i   (wdata_i[CB_GO]),
    .clr_wr_i  (wdata_i[CB_CLR]),
    .done_i    (done_i),
    .en_o      (en),
    .idle_o    (idle),
    .flag_o    (irq_flag),
    .go_o      (go_o),
    .irq_o     (irq_o)
  );

  assign desc_addr_o = {base, 4'b0000};

  always_comb begin
    rdata_o = '0;
    if (sel_cnt) begin
      rdata_o[CNT_W-1:0] = xfer_bytes_o;
    end else if (sel_ptr) begin
      rdata_o[DW-1:PB_ADDR] = base;
      rdata_o[PB_DIR]       = dir_o;
      rdata_o[PB_SPACE]     = 1'b1;
    end else if (sel_ctrl) begin
      rdata_o[CB_EN]   = en;
      rdata_o[CB_IDLE] = idle;
    end
  end
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic go_o,
  input logic done_i,
  input logic irq_o,
  input logic idle,
  input logic en,
  input logic irq_flag
);
  // R5
  go_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |=> !go_o);
  // R5
  go_marks_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> !idle);
  // R7
  go_from_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> $past(idle));
  // R8
  done_returns_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !idle) |=> (idle && irq_flag));
  // R8
  irq_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en && irq_flag));
  // R10
  flag_rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_flag) |-> ($past(done_i) && !$past(idle)));
endmodule

bind dma_chan_regs dma_chan_regs_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .go_o     (go_o),
  .done_i   (done_i),
  .irq_o    (irq_o),
  .idle     (idle),
  .en       (en),
  .irq_flag (irq_flag)
);

// File: tb/sim_dma_chan_regs.sv
`timescale 1ns/1ps
module sim_dma_chan_regs;
  localparam int CNT_W  = 8;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;
  logic              done_i = 1'b0;
  logic              go_o, dir_o, irq_o;
  logic [CNT_W-1:0]  xfer_bytes_o;
  logic [31:0]       desc_addr_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dma_chan_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .done_i(done_i), .go_o(go_o),
    .xfer_bytes_o(xfer_bytes_o), .desc_addr_o(desc_addr_o), .dir_o(dir_o),
    .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // all driving happens on negedges
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
    addr_i = a;
    #0.5;
    chk(req, rdata_o, exp);
  endtask

  task automatic done_pulse();
    done_i = 1'b1;
    @(negedge clk);
    done_i = 1'b0;
  endtask

  initial begin
    #150000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk("R1 cnt", 4'h0, 32'h0);
    rd_chk("R1 ptr", 4'h4, 32'h1);
    rd_chk("R1 ctrl", 4'h8, 32'h10);
    chk("R1 go", {31'b0, go_o}, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);

    // R2 exhaustive count sweep with upper junk
    for (int i = 0; i < 256; i++) begin
      logic [31:0] d;
      d = (32'(i) * 32'h0101_0101) | 32'hFF00_0000;
      wr(4'h0, d);
      rd_chk("R2 cnt read", 4'h0, d & 32'hFF);
      chk("R2 cnt port", {24'b0, xfer_bytes_o}, d & 32'hFF);
    end

    // R3 R4 pointer sweep
    for (int i = 0; i < 128; i++) begin
      logic [31:0] d;
      d = 32'(i) * 32'h0421_0843 + 32'(i);
      wr(4'h4, d);
      rd_chk("R3 ptr read", 4'h4, (d & 32'hFFFF_FFF8) | 32'h1);
      chk("R3 desc addr", desc_addr_o, d & 32'hFFFF_FFF0);
      chk("R4 dir", {31'b0, dir_o}, {31'b0, d[3]});
    end

    // R11 unmapped and misaligned
    wr(4'h0, 32'h5A);
    wr(4'h4, 32'hABCD_EF08);
    for (int a = 0; a < 16; a++) begin
      if (a == 0 || a == 4 || a == 8) continue;
      wr(4'(a), 32'hFFFF_FFFF);
      rd_chk("R11 unmapped read", 4'(a), 32'h0);
    end
    rd_chk("R11 cnt kept", 4'h0, 32'h5A);
    rd_chk("R11 ptr kept", 4'h4, 32'hABCD_EF09);
    rd_chk("R11 ctrl kept", 4'h8, 32'h10);
    chk("R11 no go", {31'b0, go_o}, 32'h0);

    // R6 launch without enable
    wr(4'h8, 32'h2);
    chk("R6 no go", {31'b0, go_o}, 32'h0);
    rd_chk("R6 ctrl", 4'h8, 32'h10);

    // R12 enable, all-ones write reads back only en and inactive
    wr(4'h8, 32'hFFFF_FFF9 & ~32'h2);
    rd_chk("R12 ctrl mask", 4'h8, 32'h11);

    // R5 accepted launch
    wr(4'h8, 32'h3);
    chk("R5 go high", {31'b0, go_o}, 32'h1);
    rd_chk("R5 active", 4'h8, 32'h01);
    @(negedge clk);
    chk("R5 go one cycle", {31'b0, go_o}, 32'h0);

    // R7 launch while active
    wr(4'h8, 32'h3);
    chk("R7 no go", {31'b0, go_o}, 32'h0);
    @(negedge clk);
    chk("R7 no go later", {31'b0, go_o}, 32'h0);
    rd_chk("R7 still active", 4'h8, 32'h01);

    // R8 completion
    done_pulse();
    rd_chk("R8 inactive", 4'h8, 32'h11);
    chk("R8 irq", {31'b0, irq_o}, 32'h1);
    wr(4'h8, 32'h0);
    chk("R8 irq masked", {31'b0, irq_o}, 32'h0);
    wr(4'h8, 32'h1);
    chk("R8 irq unmasked", {31'b0, irq_o}, 32'h1);

    // R9 clear
    wr(4'h8, 32'h1);
    chk("R9 zero no effect", {31'b0, irq_o}, 32'h1);
    wr(4'h8, 32'h9);
    chk("R9 cleared", {31'b0, irq_o}, 32'h0);

    // R8 done while inactive ignored
    done_pulse();
    chk("R8 idle done", {31'b0, irq_o}, 32'h0);
    rd_chk("R8 idle ctrl", 4'h8, 32'h11);

    // R10 completion vs clear in same cycle
    wr(4'h8, 32'h3);
    chk("R10 go", {31'b0, go_o}, 32'h1);
    done_i = 1'b1;
    wr(4'h8, 32'h9);
    done_i = 1'b0;
    chk("R10 flag wins", {31'b0, irq_o}, 32'h1);
    rd_chk("R10 ctrl", 4'h8, 32'h11);
    wr(4'h8, 32'h9);
    chk("R10 later clear", {31'b0, irq_o}, 32'h0);

    // R5 relaunch after completion
    wr(4'h8, 32'h3);
    chk("R5 relaunch", {31'b0, go_o}, 32'h1);
    done_pulse();
    rd_chk("R5 relaunch done", 4'h8, 32'h11);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule